// File: doc/BRIEF.md
# Multi-Bank Ternary Rule Matcher

This block is a small ternary classifier for access-control and forwarding rules. A wide header key comes in, cut into fixed 36-bit slices. Each of several banks picks one slice through its own select, then compares it against a set of rows. Every row holds a value, a care mask and a valid bit. Inside a bank the matching row with the lowest index wins, and its row number selects an entry in that bank's action memory.

Banks can be chained. When a bank's chain bit is set, its hit counts only if the bank just below it also produced a counted hit, so several banks together can qualify a key wider than one slice. Each action entry carries several independent action slots, and each slot has an enable, a precedence and a data field. Across banks the slots are merged one slot at a time: the highest precedence wins, and on a tie the higher-numbered bank wins. This lets rule levels overlap.

A new key can be presented every clock. The merged action and a hit flag come out in order, a fixed six cycles later. Rules and their actions are loaded through a single-row write port.

Top module: `tmr_matcher`

## Requirements
- R1: A valid row matches a slice when every bit that has a 1 in the row's care mask equals the corresponding value bit. Bits whose care bit is 0 are ignored.
- R2: A row whose valid bit is 0 never matches, whatever its value and mask. After reset, a lookup in a table where no valid row has been written gives no hit.
- R3: When several rows of one bank match, the bank takes the action stored at the lowest matching row index.
- R4: Bank b compares the key slice whose number is given in i_sel[b*SEL_W +: SEL_W]. Slice s is made of key bits [s*36 +: 36].
- R5: For a bank b of 1 or higher with i_chain[b] = 1, the hit counts only when bank b-1 has a counted hit. This rule applies down the chain. i_chain[0] has no effect.
- R6: An action word holds slots that are 12 bits wide. Slot t sits at bits [t*12 +: 12]. Inside a slot, bit 11 is the enable, bits 10:8 are the precedence and bits 7:0 are the data. For each slot, the output takes the enabled slot with the highest precedence among the banks with a counted hit. On equal precedence the higher bank number wins.
- R7: o_hit is 1 when at least one bank has a counted hit. A slot is output as all zeros when no counted bank enables it. When o_hit or o_valid is 0, o_action is all zeros.
- R8: A lookup driven before clock edge k shows up on o_valid, o_hit and o_action just after edge k+5. The block accepts one lookup per cycle, and results come out in the order the lookups went in.
- R9: Synchronous active-high reset invalidates every row and empties the pipeline. Right after reset, o_valid, o_hit and o_action are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Lookup strobe |
| i_key | input | NUM_SLICES*36 | Header key, cut into 36-bit slices |
| i_sel | input | NUM_BANKS*SEL_W | Slice select for each bank |
| i_chain | input | NUM_BANKS | Chain bits: bank b is gated by bank b-1 |
| wr_en | input | 1 | Write one row and its action |
| wr_bank | input | BANK_W | Bank to write |
| wr_row | input | RIDX_W | Row to write |
| wr_valid | input | 1 | Valid bit of the row |
| wr_value | input | 36 | Compare value |
| wr_mask | input | 36 | Care mask (1 means the bit is compared) |
| wr_action | input | ACT_W | Action word for the row (three slots) |
| o_valid | output | 1 | Result strobe |
| o_hit | output | 1 | At least one bank has a counted hit |
| o_action | output | ACT_W | Merged action word |

## Verification
The bench builds the block with four banks, eight rows per bank and four key slices. Every row can then be loaded and checked in a short run. Two-bit slice selects reach every slice, and a four-deep chain can gate two banks in a row. A precedence field of three bits, filled at random, makes ties between banks common. So the tie-break and the per-slot merge are exercised by the random lookups as well as by the directed cases. Back-to-back lookups with idle gaps mixed in check the fixed latency and the ordering.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int SLICE_W = 36;
    localparam int PREC_W  = 3;
    localparam int ADATA_W = 8;
    localparam int N_SLOT  = 3;

    typedef struct packed {
        logic               en;
        logic [PREC_W-1:0]  prec;
        logic [ADATA_W-1:0] data;
    } act_slot_t;

    typedef act_slot_t [N_SLOT-1:0] act_entry_t;

    localparam int ACT_W = $bits(act_entry_t);

    typedef struct packed {
        logic               vld;
        logic [SLICE_W-1:0] value;
        logic [SLICE_W-1:0] care;
    } rule_t;

    function automatic logic row_match(rule_t r, logic [SLICE_W-1:0] k);
        return r.vld && (((k ^ r.value) & r.care) == '0);
    endfunction

    // keep cur unless cand is enabled with precedence at least as high
    function automatic act_slot_t slot_pick(act_slot_t cur, act_slot_t cand);
        if (cand.en && (!cur.en || cand.prec >= cur.prec))
            return cand;
        return cur;
    endfunction

endpackage

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter  int ROWS   = 16,
    localparam int RIDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_row,
    input  rule_t             wr_rule,
    input  logic [SLICE_W-1:0] lk_slice,
    output logic              hit_q,
    output logic [RIDX_W-1:0] idx_q
);

    rule_t            rows [ROWS];
    logic [ROWS-1:0]  match_q;
    logic             hit_d;
    logic [RIDX_W-1:0] idx_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) rows[r] <= '0;
        end else if (wr_en) begin
            rows[wr_row] <= wr_rule;
        end
    end

    // stage 2: per-row compare
    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
        end else begin
            for (int r = 0; r < ROWS; r++)
                match_q[r] <= row_match(rows[r], lk_slice);
        end
    end

    // stage 3: lowest index wins
    always_comb begin
        hit_d = 1'b0;
        idx_d = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (match_q[r]) begin
                hit_d = 1'b1;
                idx_d = RIDX_W'(r);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b0;
            idx_q <= '0;
        end else begin
            hit_q <= hit_d;
            idx_q <= idx_d;
        end
    end

endmodule

// File: rtl/tmr_action_mem.sv
module tmr_action_mem
    import tmr_pkg::*;
#(
    parameter  int ROWS   = 16,
    localparam int RIDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_row,
    input  act_entry_t        wr_act,
    input  logic [RIDX_W-1:0] rd_idx,
    output act_entry_t        rd_act_q
);

    act_entry_t mem [ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= '0;
        end else if (wr_en) begin
            mem[wr_row] <= wr_act;
        end
    end

    // stage 4: registered read
    always_ff @(posedge clk) begin
        if (rst) rd_act_q <= '0;
        else     rd_act_q <= mem[rd_idx];
    end

endmodule

// File: rtl/tmr_matcher.sv
module tmr_matcher
    import tmr_pkg::*;
#(
    parameter  int NUM_BANKS  = 4,
    parameter  int ROWS       = 16,
    parameter  int NUM_SLICES = 4,
    localparam int SEL_W      = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
    localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int RIDX_W     = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int KEY_W      = NUM_SLICES * SLICE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       i_valid,
    input  logic [KEY_W-1:0]           i_key,
    input  logic [NUM_BANKS*SEL_W-1:0] i_sel,
    input  logic [NUM_BANKS-1:0]       i_chain,
    input  logic                       wr_en,
    input  logic [BANK_W-1:0]          wr_bank,
    input  logic [RIDX_W-1:0]          wr_row,
    input  logic                       wr_valid,
    input  logic [SLICE_W-1:0]         wr_value,
    input  logic [SLICE_W-1:0]         wr_mask,
    input  logic [ACT_W-1:0]           wr_action,
    output logic                       o_valid,
    output logic                       o_hit,
    output logic [ACT_W-1:0]           o_action
);

    rule_t                 wr_rule;
    act_entry_t            wr_act;
    logic [SLICE_W-1:0]    slice_q [NUM_BANKS];
    logic [NUM_BANKS-1:0]  hit3;
    logic [RIDX_W-1:0]     idx3 [NUM_BANKS];
    act_entry_t            act4 [NUM_BANKS];
    logic [NUM_BANKS-1:0]  eff_d;
    logic [NUM_BANKS-1:0]  eff4_q;
    act_entry_t            merged_d;
    act_entry_t            merged5_q;
    logic                  hit5_q;
    logic [NUM_BANKS-1:0]  chain1_q, chain2_q, chain3_q;
    logic                  vld1_q, vld2_q, vld3_q, vld4_q, vld5_q;
    logic                  unused_chain0;

    assign wr_rule       = '{vld: wr_valid, value: wr_value, care: wr_mask};
    assign wr_act        = act_entry_t'(wr_action);
    assign unused_chain0 = chain3_q[0];

    // stage 1: slice selection
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NUM_BANKS; b++) slice_q[b] <= '0;
        end else begin
            for (int b = 0; b < NUM_BANKS; b++)
                slice_q[b] <= i_key[i_sel[b*SEL_W +: SEL_W]*SLICE_W +: SLICE_W];
        end
    end

    // stages 2..4 live in the banks and action memories
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_we;
        assign bank_we = wr_en && (wr_bank == BANK_W'(b));

        tmr_bank #(.ROWS(ROWS)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (bank_we),
            .wr_row   (wr_row),
            .wr_rule  (wr_rule),
            .lk_slice (slice_q[b]),
            .hit_q    (hit3[b]),
            .idx_q    (idx3[b])
        );

        tmr_action_mem #(.ROWS(ROWS)) u_act (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (bank_we),
            .wr_row   (wr_row),
            .wr_act   (wr_act),
            .rd_idx   (idx3[b]),
            .rd_act_q (act4[b])
        );
    end

    // cascade qualification ripples upward from bank 0
    always_comb begin
        eff_d[0] = hit3[0];
        for (int b = 1; b < NUM_BANKS; b++)
            eff_d[b] = hit3[b] && (!chain3_q[b] || eff_d[b-1]);
    end

    // per-slot precedence merge; later (higher) banks win ties
    always_comb begin
        for (int t = 0; t < N_SLOT; t++) begin
            merged_d[t] = '0;
            for (int b = 0; b < NUM_BANKS; b++)
                if (eff4_q[b]) merged_d[t] = slot_pick(merged_d[t], act4[b][t]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld1_q    <= 1'b0;
            vld2_q    <= 1'b0;
            vld3_q    <= 1'b0;
            vld4_q    <= 1'b0;
            vld5_q    <= 1'b0;
            chain1_q  <= '0;
            chain2_q  <= '0;
            chain3_q  <= '0;
            eff4_q    <= '0;
            merged5_q <= '0;
            hit5_q    <= 1'b0;
            o_valid   <= 1'b0;
            o_hit     <= 1'b0;
            o_action  <= '0;
        end else begin
            vld1_q    <= i_valid;
            vld2_q    <= vld1_q;
            vld3_q    <= vld2_q;
            vld4_q    <= vld3_q;
            vld5_q    <= vld4_q;
            chain1_q  <= i_chain;
            chain2_q  <= chain1_q;
            chain3_q  <= chain2_q;
            eff4_q    <= vld3_q ? eff_d : '0;
            merged5_q <= merged_d;
            hit5_q    <= |eff4_q;
            o_valid   <= vld5_q;
            o_hit     <= hit5_q;
            o_action  <= merged5_q;
        end
    end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             i_valid,
    input logic             wr_en,
    input logic             wr_valid,
    input logic             o_valid,
    input logic             o_hit,
    input logic [ACT_W-1:0] o_action
);

    logic [2:0] age;
    logic       seen_rule;

    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) seen_rule <= 1'b0;
        else if (wr_en && wr_valid) seen_rule <= 1'b1;
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd6) |-> (o_valid == $past(i_valid, 6)));  // R8

    AST_MISS_NO_ACTION: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_hit) |-> (o_action == '0));  // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !o_valid |-> (!o_hit && o_action == '0));  // R7

    AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        !seen_rule |-> !o_hit);  // R2

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!o_valid && !o_hit));  // R9

endmodule

bind tmr_matcher tmr_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .i_valid  (i_valid),
    .wr_en    (wr_en),
    .wr_valid (wr_valid),
    .o_valid  (o_valid),
    .o_hit    (o_hit),
    .o_action (o_action)
);

// File: tb/tmr_matcher_bench.sv
`timescale 1ns/1ps
module tmr_matcher_bench;
    import tmr_pkg::*;

    localparam int NB = 4;
    localparam int ROWS = 8;
    localparam int NS = 4;
    localparam int SW = 36;
    localparam int SEL_W = 2;
    localparam int BANK_W = 2;
    localparam int RIDX_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic i_valid = 1'b0;
    logic [NS*SW-1:0] i_key = '0;
    logic [NB*SEL_W-1:0] i_sel = '0;
    logic [NB-1:0] i_chain = '0;
    logic wr_en = 1'b0;
    logic [BANK_W-1:0] wr_bank = '0;
    logic [RIDX_W-1:0] wr_row = '0;
    logic wr_valid = 1'b0;
    logic [SW-1:0] wr_value = '0, wr_mask = '0;
    logic [ACT_W-1:0] wr_action = '0;
    logic o_valid, o_hit;
    logic [ACT_W-1:0] o_action;

    tmr_matcher #(.NUM_BANKS(NB), .ROWS(ROWS), .NUM_SLICES(NS)) u_tmr_matcher (
        .clk(clk), .rst(rst), .i_valid(i_valid), .i_key(i_key), .i_sel(i_sel),
        .i_chain(i_chain), .wr_en(wr_en), .wr_bank(wr_bank), .wr_row(wr_row),
        .wr_valid(wr_valid), .wr_value(wr_value), .wr_mask(wr_mask),
        .wr_action(wr_action), .o_valid(o_valid), .o_hit(o_hit), .o_action(o_action)
    );

    always #2.5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bench copy of the rule table
    bit            m_vld  [NB][ROWS];
    logic [SW-1:0] m_val  [NB][ROWS];
    logic [SW-1:0] m_care [NB][ROWS];
    logic [ACT_W-1:0] m_act [NB][ROWS];

    logic             q_hit [$];
    logic [ACT_W-1:0] q_act [$];
    int               q_stamp [$];
    string            q_tag [$];

    function automatic logic [11:0] slot(bit en, int prec, int data);
        return {en, 3'(prec), 8'(data)};
    endfunction

    function automatic logic [SW-1:0] rand36();
        return SW'({$urandom, $urandom});
    endfunction

    function automatic logic [NS*SW-1:0] rand_key();
        return (NS*SW)'({$urandom, $urandom, $urandom, $urandom, $urandom});
    endfunction

    function automatic logic [NB*SEL_W-1:0] ident_sel();
        logic [NB*SEL_W-1:0] s;
        for (int b = 0; b < NB; b++) s[b*SEL_W +: SEL_W] = SEL_W'(b);
        return s;
    endfunction

    function automatic void model(input logic [NS*SW-1:0] key,
                                  input logic [NB*SEL_W-1:0] sel,
                                  input logic [NB-1:0] chain,
                                  output logic hit, output logic [ACT_W-1:0] act);
        bit eff [NB];
        logic [ACT_W-1:0] bact [NB];
        hit = 1'b0;
        act = '0;
        for (int b = 0; b < NB; b++) begin
            logic [SW-1:0] sl;
            bit found;
            int s;
            s = int'(sel[b*SEL_W +: SEL_W]);
            sl = SW'(key >> (s*SW));
            found = 0;
            bact[b] = '0;
            for (int r = 0; r < ROWS; r++)
                if (!found && m_vld[b][r] && (((sl ^ m_val[b][r]) & m_care[b][r]) == '0)) begin
                    found = 1;
                    bact[b] = m_act[b][r];
                end
            eff[b] = found && (b == 0 || !chain[b] || eff[b-1]);
            if (eff[b]) hit = 1'b1;
        end
        for (int t = 0; t < N_SLOT; t++) begin
            logic [11:0] best;
            best = '0;
            for (int b = 0; b < NB; b++) begin
                logic [11:0] c;
                c = bact[b][t*12 +: 12];
                if (eff[b] && c[11] && (!best[11] || c[10:8] >= best[10:8])) best = c;
            end
            act[t*12 +: 12] = best;
        end
    endfunction

    task automatic write_rule(int b, int r, bit v, logic [SW-1:0] val,
                              logic [SW-1:0] care, logic [ACT_W-1:0] act);
        wr_en = 1'b1;
        wr_bank = BANK_W'(b);
        wr_row = RIDX_W'(r);
        wr_valid = v;
        wr_value = val;
        wr_mask = care;
        wr_action = act;
        m_vld[b][r] = v;
        m_val[b][r] = val;
        m_care[b][r] = care;
        m_act[b][r] = act;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // called at a negedge; returns at the next negedge
    task automatic lookup(logic [NS*SW-1:0] key, logic [NB*SEL_W-1:0] sel,
                          logic [NB-1:0] chain, string tag);
        logic eh;
        logic [ACT_W-1:0] ea;
        i_valid = 1'b1;
        i_key = key;
        i_sel = sel;
        i_chain = chain;
        model(key, sel, chain, eh, ea);
        q_hit.push_back(eh);
        q_act.push_back(ea);
        q_stamp.push_back(cyc + 6);
        q_tag.push_back(tag);
        @(negedge clk);
        i_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (9) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst && o_valid) begin
            tests++;
            if (q_hit.size() == 0) begin
                fails++;
                $display("FAIL R8: result with no lookup pending, got hit=%0b expected none", o_hit);
            end else begin
                if (q_stamp[0] != cyc) begin
                    fails++;
                    $display("FAIL R8: result in cycle %0d, expected cycle %0d", cyc, q_stamp[0]);
                end
                tests++;
                if (o_hit !== q_hit[0] || o_action !== q_act[0]) begin
                    fails++;
                    $display("FAIL %s: hit=%0b act=%h, expected hit=%0b act=%h",
                             q_tag[0], o_hit, o_action, q_hit[0], q_act[0]);
                end
                void'(q_hit.pop_front());
                void'(q_act.pop_front());
                void'(q_stamp.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    task automatic check_quiet(string tag);
        tests++;
        if (o_valid !== 1'b0 || o_hit !== 1'b0 || o_action !== '0) begin
            fails++;
            $display("FAIL %s: valid=%0b hit=%0b act=%h, expected 0 0 0", tag, o_valid, o_hit, o_action);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        logic [NS*SW-1:0] k;
        logic [NB*SEL_W-1:0] sel;
        void'($urandom(32'd7177));
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < ROWS; r++) begin
                m_vld[b][r] = 0; m_val[b][r] = '0; m_care[b][r] = '0; m_act[b][r] = '0;
            end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_quiet("R9 reset state");
        sel = ident_sel();

        // R2: empty table, then an invalid match-all row
        lookup(rand_key(), sel, '0, "R2 empty table");
        drain();
        write_rule(0, 0, 0, '0, '0, {slot(1,7,8'hEE), slot(1,7,8'hEE), slot(1,7,8'hEE)});
        lookup(rand_key(), sel, '0, "R2 invalid row");
        drain();

        // R1: care-masked compare on the low byte
        write_rule(0, 1, 1, 36'h0000000AB, 36'h0000000FF, {slot(0,0,0), slot(0,0,0), slot(1,1,8'h11)});
        k = rand_key(); k[7:0] = 8'hAB;
        lookup(k, sel, '0, "R1 masked match");
        k[7:0] = 8'hAC;
        lookup(k, sel, '0, "R1 masked miss");
        drain();

        // R3: lower row beats a match-all row below it
        write_rule(0, 3, 1, '0, '0, {slot(0,0,0), slot(0,0,0), slot(1,1,8'h33)});
        k = rand_key(); k[7:0] = 8'hAB;
        lookup(k, sel, '0, "R3 lowest row wins");
        k[7:0] = 8'h00;
        lookup(k, sel, '0, "R3 fallback row");
        drain();

        // R4: bank 1 exact match on a chosen slice
        write_rule(1, 0, 1, 36'h123456789, {SW{1'b1}}, {slot(0,0,0), slot(1,2,8'h44), slot(0,0,0)});
        k = rand_key(); k[2*SW +: SW] = 36'h123456789; k[SW +: SW] = 36'h0;
        sel = ident_sel(); sel[1*SEL_W +: SEL_W] = 2'd2;
        lookup(k, sel, '0, "R4 slice 2 selected");
        sel[1*SEL_W +: SEL_W] = 2'd1;
        lookup(k, sel, '0, "R4 slice 1 selected");
        drain();

        // R6: equal precedence, higher bank wins; slots merge separately
        write_rule(2, 0, 1, '0, '0, {slot(1,3,8'h77), slot(0,0,0), slot(1,5,8'h55)});
        write_rule(3, 0, 1, '0, '0, {slot(0,0,0), slot(1,1,8'h88), slot(1,5,8'h66)});
        sel = ident_sel();
        lookup(rand_key(), sel, '0, "R6 tie to higher bank");
        drain();

        // R5: cascade gating by bank 1
        k = rand_key(); k[SW +: SW] = 36'h0;
        lookup(k, sel, 4'b1100, "R5 chain blocked");
        k[SW +: SW] = 36'h123456789;
        lookup(k, sel, 4'b1100, "R5 chain passes");
        k[SW +: SW] = 36'h0;
        lookup(k, sel, 4'b1000, "R5 chain one link");
        lookup(k, sel, 4'b0001, "R5 bit0 ignored");
        drain();

        // random table and back-to-back lookups (R1 R3 R6 R7 R8)
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < ROWS; r++)
                write_rule(b, r, ($urandom % 4) != 0, rand36(), rand36() & rand36() & rand36(),
                           {slot($urandom%2==1, $urandom%8, $urandom%256),
                            slot($urandom%2==1, $urandom%8, $urandom%256),
                            slot($urandom%2==1, $urandom%8, $urandom%256)});
        for (int n = 0; n < 400; n++) begin
            k = rand_key();
            for (int b = 0; b < NB; b++) sel[b*SEL_W +: SEL_W] = SEL_W'($urandom);
            if ($urandom % 2 == 1) begin
                int bb, rr, ss;
                bb = $urandom % NB; rr = $urandom % ROWS; ss = $urandom % NS;
                k[ss*SW +: SW] = m_val[bb][rr];
            end
            lookup(k, sel, NB'($urandom), "R6 random merge");
            if ($urandom % 8 == 0) @(negedge clk);
        end
        drain();

        // R9: reset invalidates loaded rows
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int b = 0; b < NB; b++)
            for (int r = 0; r < ROWS; r++) m_vld[b][r] = 0;
        check_quiet("R9 after mid-run reset");
        lookup(rand_key(), ident_sel(), '0, "R9 rows cleared");
        drain();

        tests++;
        if (q_hit.size() != 0) begin
            fails++;
            $display("FAIL R8: %0d results missing, expected 0", q_hit.size());
        end
        finish_run();
    end

endmodule